// File: doc/BRIEF.md
# Paced Interrupt Aggregation Controller

This block gathers interrupt events from a packet switch and a management-interface unit and presents them to a processor as 25 interrupt lines. Sixteen of them are completion lines (eight for receive, eight for transmit), and each of these can be rate-limited on its own. A rate-limited line asserts at most a programmable number of times per pacing window. An event that arrives after a line has used up its allowance is held, not dropped, and is delivered when the next window opens. This keeps the interrupt service rate bounded when traffic is heavy.

The other lines are never rate-limited. The eight receive-threshold lines pass their sources straight through. A single miscellaneous line is the OR of six status events, and a mask picks which of those events count. All outputs are combinational in the current inputs and the registered channel state, so an event that is allowed appears in the same cycle it arrives. Each source is sampled once per clock as a one-cycle event. The configuration inputs (window length, per-channel enables and per-channel limits) are expected to be driven from a register bank outside this block.

Top module: `irq_pacer`

## Requirements
- R1: While reset is asserted and just after it is released, with no source active, every output is low, every held event is cleared and every per-window count is zero.
- R2: Each receive-threshold output equals its source in the same cycle, whatever the pacing configuration.
- R3: The miscellaneous output is the OR of `misc_evt_i & misc_mask_i` in the same cycle. The bit assignment is: 0 host error, 1 statistics level, 2 and 3 management user access 0 and 1, 4 and 5 management link change 0 and 1.
- R4: A window starts on the first cycle after reset is released and then every `win_cycles_i` cycles. A value of 0 or 1 makes every cycle a window start. Every window start clears all per-window counts.
- R5: On an enabled channel, an event (new or held) asserts the output in the same cycle when the channel's count for the current window is below its limit, and each assertion adds one to that count.
- R6: On an enabled channel whose count has reached its limit, the output stays low and the event is held. Several events held on one channel merge into a single pending event.
- R7: On an enabled channel with a nonzero limit, a held event is asserted on the first cycle of the next window.
- R8: On an enabled channel with a limit of 0, events are held for as long as pacing stays enabled, and the output never asserts.
- R9: On a channel with pacing disabled, the output is the source OR any held event. The held event is then cleared, and the assertion is not counted.
- R10: Receive channel i uses `rx_pace_en_i[i]` and `rx_lim_i[4i+3:4i]`, and drives `rx_irq_o[i]`. Transmit channels map the same way through the `tx_` ports. Channels do not affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| win_cycles_i | input | 12 | Pacing window length in cycles |
| rx_pace_en_i | input | 8 | Pacing enable per receive channel |
| tx_pace_en_i | input | 8 | Pacing enable per transmit channel |
| rx_lim_i | input | 32 | 4-bit assertion limit per receive channel |
| tx_lim_i | input | 32 | 4-bit assertion limit per transmit channel |
| rx_src_i | input | 8 | Receive completion events |
| tx_src_i | input | 8 | Transmit completion events |
| thr_src_i | input | 8 | Receive threshold events |
| misc_evt_i | input | 6 | Miscellaneous events |
| misc_mask_i | input | 6 | Miscellaneous event mask |
| rx_irq_o | output | 8 | Receive completion interrupts |
| tx_irq_o | output | 8 | Transmit completion interrupts |
| thr_irq_o | output | 8 | Receive threshold interrupts |
| misc_irq_o | output | 1 | Miscellaneous interrupt |

## Verification
The hardest state to reach is a channel that is at its limit and holding an event at the exact cycle a new window opens. For that cycle to occur, the bursts have to be dense enough to use up the allowance early in the window, and the window must be short enough that many boundaries pass.

The stimulus runs with short windows of 8, 5 and 0 cycles. It sends bursts at about one event in three cycles, with limits from 0 to 4, and sometimes turns pacing off on a channel while it holds an event. A directed part then drives one receive channel with a limit of one, so that it fills, holds and releases against an idle background.

// File: rtl/irq_pace_pkg.sv
package irq_pace_pkg;
  localparam int unsigned NCH    = 8;
  localparam int unsigned LIM_W  = 4;
  localparam int unsigned WIN_W  = 12;
  localparam int unsigned MISC_N = 6;

  typedef enum int unsigned {
    MISC_HOST_ERR = 0,
    MISC_STAT     = 1,
    MISC_USER0    = 2,
    MISC_USER1    = 3,
    MISC_LINK0    = 4,
    MISC_LINK1    = 5
  } misc_bit_e;
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
  parameter int unsigned WIN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIN_W-1:0] win_i,
  output logic             tick_o
);
  logic [WIN_W-1:0] pre_q;
  logic [WIN_W:0]   pre_inc;
  logic             wrap;

  assign pre_inc = {1'b0, pre_q} + 1'b1;
  assign wrap    = pre_inc >= {1'b0, win_i};
  assign tick_o  = (pre_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= wrap ? '0 : pre_inc[WIN_W-1:0];
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && win_i > 1) |=> (!tick_o || $past(win_i) != win_i));
endmodule

// File: rtl/irq_pace_chan.sv
module irq_pace_chan #(
  parameter int unsigned LIM_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [LIM_W-1:0] lim_i,
  input  logic             src_i,
  output logic             irq_o
);
  logic             pend_q, pend_d;
  logic [LIM_W-1:0] cnt_q, cnt_d, cnt_base;
  logic             req, allow, fire;

  assign req      = src_i | pend_q;
  // window start: count restarts, so only a zero limit blocks
  assign allow    = tick_i ? (lim_i != '0) : (cnt_q < lim_i);
  assign fire     = req & (~en_i | allow);
  assign irq_o    = fire;
  assign pend_d   = req & ~fire;
  assign cnt_base = tick_i ? '0 : cnt_q;
  assign cnt_d    = cnt_base + {{(LIM_W-1){1'b0}}, en_i & fire};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  // R6
  held_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && src_i && !irq_o) |=> pend_q);
  // R6
  limit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i && cnt_q >= lim_i) |-> !irq_o);
  // R7
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && pend_q && lim_i != '0) |-> irq_o);
  // R8
  zero_lim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && lim_i == '0) |-> !irq_o);
  // R9
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && src_i) |-> (irq_o ##1 !pend_q));
endmodule

// File: rtl/irq_misc_sel.sv
module irq_misc_sel #(
  parameter int unsigned MISC_N = 6
) (
  input  logic [MISC_N-1:0] evt_i,
  input  logic [MISC_N-1:0] mask_i,
  output logic              irq_o
);
  assign irq_o = |(evt_i & mask_i);
endmodule

// File: rtl/irq_pacer.sv
module irq_pacer
  import irq_pace_pkg::*;
#(
  parameter int unsigned N_CH   = NCH,
  parameter int unsigned L_W    = LIM_W,
  parameter int unsigned W_W    = WIN_W,
  parameter int unsigned M_N    = MISC_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W_W-1:0]    win_cycles_i,
  input  logic [N_CH-1:0]   rx_pace_en_i,
  input  logic [N_CH-1:0]   tx_pace_en_i,
  input  logic [N_CH*L_W-1:0] rx_lim_i,
  input  logic [N_CH*L_W-1:0] tx_lim_i,
  input  logic [N_CH-1:0]   rx_src_i,
  input  logic [N_CH-1:0]   tx_src_i,
  input  logic [N_CH-1:0]   thr_src_i,
  input  logic [M_N-1:0]    misc_evt_i,
  input  logic [M_N-1:0]    misc_mask_i,
  output logic [N_CH-1:0]   rx_irq_o,
  output logic [N_CH-1:0]   tx_irq_o,
  output logic [N_CH-1:0]   thr_irq_o,
  output logic              misc_irq_o
);
  localparam int unsigned NPACED = 2 * N_CH;

  logic                    tick;
  logic [NPACED-1:0]       en_all, src_all, irq_all;
  logic [NPACED*L_W-1:0]   lim_all;

  assign en_all  = {tx_pace_en_i, rx_pace_en_i};
  assign src_all = {tx_src_i, rx_src_i};
  assign lim_all = {tx_lim_i, rx_lim_i};

  irq_tick_gen #(.WIN_W(W_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .win_i (win_cycles_i),
    .tick_o(tick)
  );

  for (genvar g = 0; g < NPACED; g++) begin : g_chan
    irq_pace_chan #(.LIM_W(L_W)) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick),
      .en_i  (en_all[g]),
      .lim_i (lim_all[g*L_W +: L_W]),
      .src_i (src_all[g]),
      .irq_o (irq_all[g])
    );
  end

  assign rx_irq_o  = irq_all[N_CH-1:0];
  assign tx_irq_o  = irq_all[NPACED-1:N_CH];
  assign thr_irq_o = thr_src_i;

  irq_misc_sel #(.MISC_N(M_N)) u_misc (
    .evt_i (misc_evt_i),
    .mask_i(misc_mask_i),
    .irq_o (misc_irq_o)
  );

  // R2
  thr_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(thr_src_i[0]) |-> thr_irq_o[0]);
endmodule

// File: tb/sim_irq_pacer.sv
`timescale 1ns/1ps
module sim_irq_pacer;
  localparam int N = 8;
  localparam int LW = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [11:0] win_cycles_i = 12'd8;
  logic [N-1:0] rx_pace_en_i = '0, tx_pace_en_i = '0;
  logic [N*LW-1:0] rx_lim_i = '0, tx_lim_i = '0;
  logic [N-1:0] rx_src_i = '0, tx_src_i = '0, thr_src_i = '0;
  logic [5:0] misc_evt_i = '0, misc_mask_i = '0;
  logic [N-1:0] rx_irq_o, tx_irq_o, thr_irq_o;
  logic misc_irq_o;

  int n_chk = 0, n_fail = 0;
  int m_pre = 0;
  int m_pend[2*N];
  int m_cnt[2*N];
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  irq_pacer u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit g_en(int c);
    return (c < N) ? rx_pace_en_i[c] : tx_pace_en_i[c-N];
  endfunction
  function automatic int g_lim(int c);
    return (c < N) ? int'(rx_lim_i[c*LW +: LW]) : int'(tx_lim_i[(c-N)*LW +: LW]);
  endfunction
  function automatic bit g_src(int c);
    return (c < N) ? rx_src_i[c] : tx_src_i[c-N];
  endfunction
  function automatic bit g_out(int c);
    return (c < N) ? rx_irq_o[c] : tx_irq_o[c-N];
  endfunction

  // at a negedge with inputs set: check, advance model across posedge, return at next negedge
  task automatic step();
    bit tick;
    bit req[2*N];
    bit f[2*N];
    string tag;
    #1;
    tick = (m_pre == 0);
    for (int c = 0; c < 2*N; c++) begin
      bit en = g_en(c);
      int lim = g_lim(c);
      bit allow;
      req[c] = g_src(c) || (m_pend[c] != 0);
      allow  = tick ? (lim != 0) : (m_cnt[c] < lim);
      f[c]   = req[c] && (!en || allow);
      if (!en) tag = "R9";
      else if (lim == 0) tag = "R8";
      else if (tick && m_pend[c] != 0) tag = "R7";
      else if (tick) tag = "R4";
      else if (m_cnt[c] >= lim) tag = "R6";
      else tag = "R5";
      chk($sformatf("%s ch%0d", tag, c), 32'(g_out(c)), 32'(f[c]));
    end
    chk("R2 thr", 32'(thr_irq_o), 32'(thr_src_i));
    chk("R3 misc", 32'(misc_irq_o), 32'(|(misc_evt_i & misc_mask_i)));
    @(posedge clk_i);
    for (int c = 0; c < 2*N; c++) begin
      m_pend[c] = (req[c] && !f[c]) ? 1 : 0;
      m_cnt[c]  = (tick ? 0 : m_cnt[c]) + ((g_en(c) && f[c]) ? 1 : 0);
    end
    m_pre = (m_pre + 1 >= int'(win_cycles_i)) ? 0 : m_pre + 1;
    @(negedge clk_i);
  endtask

  function automatic logic [N-1:0] rnd_ev(int pct);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = ($urandom % 100) < pct;
    return v;
  endfunction

  task automatic drive_rand(int pct);
    rx_src_i   = rnd_ev(pct);
    tx_src_i   = rnd_ev(pct);
    thr_src_i  = rnd_ev(50);
    misc_evt_i = 6'($urandom);
    misc_mask_i = 6'($urandom);
  endtask

  task automatic rand_lims(int maxv);
    for (int i = 0; i < N; i++) begin
      rx_lim_i[i*LW +: LW] = LW'($urandom % (maxv + 1));
      tx_lim_i[i*LW +: LW] = LW'($urandom % (maxv + 1));
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int c = 0; c < 2*N; c++) begin m_pend[c] = 0; m_cnt[c] = 0; end
    repeat (3) @(negedge clk_i);
    // R1: reset state, no sources
    chk("R1 rx", 32'(rx_irq_o), 0);
    chk("R1 tx", 32'(tx_irq_o), 0);
    chk("R1 misc", 32'(misc_irq_o), 0);
    rst_ni = 1'b1;
    step();
    // R3 directed: bit 5 only (link change 1)
    misc_evt_i = 6'b100000; misc_mask_i = 6'b100000; step();
    misc_mask_i = 6'b011111; step();
    misc_evt_i = 6'b000001; misc_mask_i = 6'b000001; step();
    // phase A: all paced, win 8, limits 1..3
    rx_pace_en_i = '1; tx_pace_en_i = '1;
    for (int k = 0; k < 300; k++) begin
      if (k % 40 == 0) begin
        rand_lims(3);
        for (int i = 0; i < 2*N; i++)
          if (i < N && rx_lim_i[i*LW +: LW] == 0) rx_lim_i[i*LW +: LW] = 1;
          else if (i >= N && tx_lim_i[(i-N)*LW +: LW] == 0) tx_lim_i[(i-N)*LW +: LW] = 1;
      end
      drive_rand(35); step();
    end
    // phase B: mixed enables, limits 0..4, win 5
    win_cycles_i = 12'd5;
    for (int k = 0; k < 400; k++) begin
      if (k % 25 == 0) begin
        rand_lims(4);
        rx_pace_en_i = 8'($urandom); tx_pace_en_i = 8'($urandom);
      end
      drive_rand(30); step();
    end
    // phase C: win 0 -> window start every cycle
    win_cycles_i = 12'd0;
    for (int k = 0; k < 100; k++) begin drive_rand(50); step(); end
    // directed R10: flush, then rx ch3 alone, limit 1, win 8
    rx_pace_en_i = '0; tx_pace_en_i = '0;
    rx_src_i = '0; tx_src_i = '0; thr_src_i = '0; misc_evt_i = '0;
    step();
    win_cycles_i = 12'd8; rx_lim_i = '0; tx_lim_i = '0;
    rx_lim_i[3*LW +: LW] = 4'd1;
    rx_pace_en_i = 8'h08;
    repeat (10) step();
    rx_src_i = 8'h08;
    #1 chk("R10 rx ch3 only", 32'(rx_irq_o), 32'(m_cnt[3] < 1 || m_pre == 0 ? 8'h08 : 8'h00));
    chk("R10 tx idle", 32'(tx_irq_o), 0);
    #0 step();
    rx_src_i = 8'h08; step();
    rx_src_i = 8'h08; step();
    rx_src_i = '0;
    repeat (20) step();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule